// File: doc/BRIEF.md
# Correlator Processor-Bus Register Interface

This block connects a serial-sync correlator to an 8-bit microprocessor bus. The bus side has active-low chip select, read and write strobes and a 3-bit address. A write takes effect on the falling edge of the write strobe, which is sampled on the system clock. The address selects one of five write targets: the 128-bit reference pattern, the 128-bit bit-select mask, the two threshold bytes, the control register and the data shift register.

The reference and mask registers are each built as eight 16-stage chains, one for each data-bus bit. Each byte write advances every chain by one stage, so sixteen writes fill a register. The first byte written ends up in the deepest positions. The two threshold bytes share one address and are loaded alternately. Reads return the live detector flags, the byte of the data shift register nearest its serial input, or the external correlation score.

The data shift register normally takes one bit from the line on each line tick. While the load control bit is set, it is instead filled a byte at a time from the bus. The bus data lines are a pad-level tristate, split into input, output and output-enable.

Top module: `corr_bus_if`

## Requirements
- R1: After reset, the reference, mask, both thresholds and the data shift register are zero. Control reads as prbs_mode=0, master_mode=0, sout_en_n=1, clear_n=1, sr_load=0. The threshold selector points at the normal threshold, and data_oe is low.
- R2: While cs_n is high, no write changes any register and data_oe stays low.
- R3: A write is one falling edge of wr_n seen while cs_n is low. The target register changes once at the first clock edge where wr_n is sampled low, however long wr_n then stays low.
- R4: A write to address 0 moves the reference contents up 8 bit positions and places the byte in bits 7:0. Data bit b feeds chain b, so after 16 writes the first byte sits in bits 127:120.
- R5: A write to address 1 loads the mask in the same way. A 17th write pushes the oldest byte out.
- R6: Writes to address 2 alternate: the first goes to the normal threshold, the next to the inverted threshold, and so on. Any write to address 3 returns the selector to the normal threshold.
- R7: A write to address 3 sets control from data bits: bit0 prbs_mode, bit1 master_mode, bit2 sout_en_n, bit3 clear_n, bit4 sr_load.
- R8: A read of address 3 drives bit0 syn_flag, bit1 inv_flag, bit2 line_clk_lvl and zeros in bits 7:3. Control bits are not readable.
- R9: A read of address 4 returns data shift register bits 7:0, and a read of address 5 returns score. A read of addresses 0, 1, 2, 6 or 7 leaves data_oe low.
- R10: With sr_load clear, each line_tick shifts the data shift register up one position with ser_in entering bit 0. With sr_load set, line_tick has no effect.
- R11: With sr_load set, a write to address 4 shifts the data shift register up 8 positions with the byte in bits 7:0. With sr_load clear, such a write is ignored.
- R12: ser_out equals data shift register bit 127 while sout_en_n is low and is 0 while sout_en_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| data_in | input | 8 | Bus data from the pad |
| data_out | output | 8 | Read data to the pad |
| data_oe | output | 1 | Pad output enable |
| syn_flag | input | 1 | Live sync-detected flag |
| inv_flag | input | 1 | Live inverted-sync flag |
| line_clk_lvl | input | 1 | Current level of the line clock |
| score | input | 8 | Correlation score |
| line_tick | input | 1 | One-cycle line-clock shift enable |
| ser_in | input | 1 | Serial line data |
| ref_bits | output | 128 | Reference pattern |
| mask_bits | output | 128 | Bit-select mask |
| thr_norm | output | 8 | Threshold for normal polarity |
| thr_inv | output | 8 | Threshold for inverted polarity |
| prbs_mode | output | 1 | Sequence-generator mode |
| master_mode | output | 1 | Cascade master select |
| sout_en_n | output | 1 | Serial output enable, active low |
| clear_n | output | 1 | Clear control, active low |
| sr_load | output | 1 | Bus-load mode for the data shift register |
| sr_bits | output | 128 | Data shift register contents |
| ser_out | output | 1 | Gated serial output |

## Verification
The assertions check on every cycle that chip select high suppresses every strobe and the output enable, and that at most one strobe fires per write edge. They also check that an edge fires only once however long wr_n stays low, that the reference advances exactly one byte per strobe and holds otherwise, that the threshold selector flips and restarts correctly, and that bus-load mode freezes the data shift register against line ticks. Only the bench scenarios can show the full byte order after sixteen writes, the mask overflow, the values seen on reads, the exact control bit positions and the serial-output gating.

// File: rtl/corr_bus_pkg.sv
package corr_bus_pkg;
  localparam logic [2:0] ADR_REF   = 3'd0;
  localparam logic [2:0] ADR_MASK  = 3'd1;
  localparam logic [2:0] ADR_THR   = 3'd2;
  localparam logic [2:0] ADR_STAT  = 3'd3;
  localparam logic [2:0] ADR_DSR   = 3'd4;
  localparam logic [2:0] ADR_SCORE = 3'd5;

  typedef struct packed {
    logic sr_load;
    logic clr_n;
    logic sout_en_n;
    logic master;
    logic prbs;
  } ctrl_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_STAT, SRC_DSR, SRC_SCORE} rd_src_t;

  localparam ctrl_t CTRL_RST = '{sr_load: 1'b0, clr_n: 1'b1, sout_en_n: 1'b1,
                                 master: 1'b0, prbs: 1'b0};

  function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
    ctrl_t c;
    c.prbs      = b[0];
    c.master    = b[1];
    c.sout_en_n = b[2];
    c.clr_n     = b[3];
    c.sr_load   = b[4];
    return c;
  endfunction

  function automatic logic [7:0] status_byte(input logic syn, input logic inv,
                                             input logic lvl);
    return {5'b00000, lvl, inv, syn};
  endfunction
endpackage

// File: rtl/corr_bus_decode.sv
module corr_bus_decode
  import corr_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic       sr_load,
  output logic       wr_edge,
  output logic       ref_stb,
  output logic       mask_stb,
  output logic       thr_stb,
  output logic       stat_stb,
  output logic       dsr_stb,
  output rd_src_t    rd_src,
  output logic       rd_oe
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  assign wr_edge  = wr_q & ~wr_n & ~cs_n;
  assign ref_stb  = wr_edge & (addr == ADR_REF);
  assign mask_stb = wr_edge & (addr == ADR_MASK);
  assign thr_stb  = wr_edge & (addr == ADR_THR);
  assign stat_stb = wr_edge & (addr == ADR_STAT);
  assign dsr_stb  = wr_edge & (addr == ADR_DSR) & sr_load;

  always_comb begin
    rd_src = SRC_NONE;
    if (!cs_n && !rd_n) begin
      unique case (addr)
        ADR_STAT:  rd_src = SRC_STAT;
        ADR_DSR:   rd_src = SRC_DSR;
        ADR_SCORE: rd_src = SRC_SCORE;
        default:   rd_src = SRC_NONE;
      endcase
    end
  end

  assign rd_oe = (rd_src != SRC_NONE);
endmodule

// File: rtl/corr_byte_chains.sv
module corr_byte_chains #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int W    = DW * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  q
);
  for (genvar b = 0; b < DW; b++) begin : g_lane
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chain <= '0;
      else if (shift_en) chain <= {chain[DEPTH-2:0], din[b]};
    end
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      assign q[DW*k + b] = chain[k];
    end
  end
endmodule

// File: rtl/corr_data_sreg.sv
module corr_data_sreg #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int W    = DW * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          bus_stb,
  input  logic [DW-1:0] din,
  input  logic          line_tick,
  input  logic          ser_in,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (bus_mode) begin
      if (bus_stb) q <= {q[W-DW-1:0], din};
    end else if (line_tick) begin
      q <= {q[W-2:0], ser_in};
    end
  end
endmodule

// File: rtl/corr_bus_if.sv
module corr_bus_if
  import corr_bus_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int W    = DW * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic          syn_flag,
  input  logic          inv_flag,
  input  logic          line_clk_lvl,
  input  logic [DW-1:0] score,
  input  logic          line_tick,
  input  logic          ser_in,
  output logic [W-1:0]  ref_bits,
  output logic [W-1:0]  mask_bits,
  output logic [DW-1:0] thr_norm,
  output logic [DW-1:0] thr_inv,
  output logic          prbs_mode,
  output logic          master_mode,
  output logic          sout_en_n,
  output logic          clear_n,
  output logic          sr_load,
  output logic [W-1:0]  sr_bits,
  output logic          ser_out
);
  logic    wr_edge, ref_stb, mask_stb, thr_stb, stat_stb, dsr_stb;
  rd_src_t rd_src;
  ctrl_t   ctrl_q;
  logic    thr_sel;
  logic [7:0] din8;

  assign din8 = 8'(data_in);

  corr_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .sr_load(ctrl_q.sr_load), .wr_edge(wr_edge),
    .ref_stb(ref_stb), .mask_stb(mask_stb), .thr_stb(thr_stb),
    .stat_stb(stat_stb), .dsr_stb(dsr_stb), .rd_src(rd_src), .rd_oe(data_oe)
  );

  corr_byte_chains #(.DW(DW), .DEPTH(DEPTH)) u_ref (
    .clk(clk), .rst_n(rst_n), .shift_en(ref_stb), .din(data_in), .q(ref_bits)
  );

  corr_byte_chains #(.DW(DW), .DEPTH(DEPTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .shift_en(mask_stb), .din(data_in), .q(mask_bits)
  );

  corr_data_sreg #(.DW(DW), .DEPTH(DEPTH)) u_dsr (
    .clk(clk), .rst_n(rst_n), .bus_mode(ctrl_q.sr_load), .bus_stb(dsr_stb),
    .din(data_in), .line_tick(line_tick), .ser_in(ser_in), .q(sr_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_norm <= '0;
      thr_inv  <= '0;
      thr_sel  <= 1'b0;
      ctrl_q   <= CTRL_RST;
    end else begin
      if (thr_stb) begin
        if (thr_sel) thr_inv  <= data_in;
        else         thr_norm <= data_in;
        thr_sel <= ~thr_sel;
      end
      if (stat_stb) begin
        ctrl_q  <= ctrl_from_byte(din8);
        thr_sel <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (rd_src)
      SRC_STAT:  data_out = DW'(status_byte(syn_flag, inv_flag, line_clk_lvl));
      SRC_DSR:   data_out = sr_bits[DW-1:0];
      SRC_SCORE: data_out = score;
      default:   data_out = '0;
    endcase
  end

  assign prbs_mode   = ctrl_q.prbs;
  assign master_mode = ctrl_q.master;
  assign sout_en_n   = ctrl_q.sout_en_n;
  assign clear_n     = ctrl_q.clr_n;
  assign sr_load     = ctrl_q.sr_load;
  assign ser_out     = ~ctrl_q.sout_en_n & sr_bits[W-1];
endmodule

// File: rtl/corr_bus_if_chk.sv
module corr_bus_if_chk #(
  parameter int DW = 8,
  parameter int W  = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         data_oe,
  input logic         wr_edge,
  input logic         ref_stb,
  input logic         mask_stb,
  input logic         thr_stb,
  input logic         stat_stb,
  input logic         dsr_stb,
  input logic         thr_sel,
  input logic         sr_load,
  input logic [W-1:0] ref_bits,
  input logic [W-1:0] sr_bits
);
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(ref_stb | mask_stb | thr_stb | stat_stb | dsr_stb | data_oe)); // R2
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_stb, mask_stb, thr_stb, stat_stb, dsr_stb})); // R3
  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_edge |=> !wr_edge); // R3
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb |=> $stable(ref_bits)); // R4
  AST_REF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> ref_bits[W-1:DW] == $past(ref_bits[W-DW-1:0])); // R4
  AST_THR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_stb |=> thr_sel != $past(thr_sel)); // R6
  AST_THR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    stat_stb |=> !thr_sel); // R6
  AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_load && !dsr_stb) |=> $stable(sr_bits)); // R10
endmodule

bind corr_bus_if corr_bus_if_chk #(.DW(DW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .data_oe(data_oe), .wr_edge(wr_edge),
  .ref_stb(ref_stb), .mask_stb(mask_stb), .thr_stb(thr_stb),
  .stat_stb(stat_stb), .dsr_stb(dsr_stb), .thr_sel(thr_sel),
  .sr_load(sr_load), .ref_bits(ref_bits), .sr_bits(sr_bits)
);

// File: tb/tb_corr_bus_if.sv
module tb_corr_bus_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic data_oe;
  logic syn_flag = 1'b0, inv_flag = 1'b0, line_clk_lvl = 1'b0;
  logic [7:0] score = '0;
  logic line_tick = 1'b0, ser_in = 1'b0;
  logic [127:0] ref_bits, mask_bits, sr_bits;
  logic [7:0] thr_norm, thr_inv;
  logic prbs_mode, master_mode, sout_en_n, clear_n, sr_load, ser_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] exp_v;

  always #4 clk = ~clk;

  corr_bus_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .syn_flag(syn_flag), .inv_flag(inv_flag), .line_clk_lvl(line_clk_lvl),
    .score(score), .line_tick(line_tick), .ser_in(ser_in),
    .ref_bits(ref_bits), .mask_bits(mask_bits), .thr_norm(thr_norm),
    .thr_inv(thr_inv), .prbs_mode(prbs_mode), .master_mode(master_mode),
    .sout_en_n(sout_en_n), .clear_n(clear_n), .sr_load(sr_load),
    .sr_bits(sr_bits), .ser_out(ser_out)
  );

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                           input bit sel, input int low_cycles);
    @(negedge clk);
    addr = a; data_in = d; cs_n = ~sel;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [2:0] a, input bit sel,
                          output logic [8:0] got);
    @(negedge clk);
    addr = a; cs_n = ~sel; rd_n = 1'b0;
    #1;
    got = {data_oe, data_out};
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic line_bit(input logic b);
    @(negedge clk);
    line_tick = 1'b1; ser_in = b;
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  // {is_read, addr, write data, expected {oe, data}}
  localparam int NV = 10;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {1'b1, 3'd3, 8'h00, 9'h105},  // R8 status flags
    {1'b1, 3'd5, 8'h00, 9'h1A5},  // R9 score
    {1'b1, 3'd6, 8'h00, 9'h000},  // R9 unused address
    {1'b1, 3'd0, 8'h00, 9'h000},  // R9 write-only address
    {1'b0, 3'd2, 8'h12, 9'h000},  // R6 normal
    {1'b0, 3'd2, 8'h34, 9'h000},  // R6 inverted
    {1'b0, 3'd2, 8'h56, 9'h000},  // R6 normal again
    {1'b0, 3'd3, 8'h08, 9'h000},  // R6 selector restart
    {1'b0, 3'd2, 8'h9A, 9'h000},  // R6 normal after restart
    {1'b1, 3'd3, 8'h00, 9'h105}   // R8 control not visible
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [8:0] got;
    logic [7:0] wb [0:16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ref", ref_bits, '0);
    check("R1 mask", mask_bits, '0);
    check("R1 sr", sr_bits, '0);
    check("R1 thr", {thr_norm, thr_inv}, '0);
    check("R1 ctrl", {prbs_mode, master_mode, sout_en_n, clear_n, sr_load}, 5'b00110);
    check("R1 oe", data_oe, 1'b0);
    check("R12 ser_out disabled", ser_out, 1'b0);

    // R2 chip select high
    bus_write(3'd0, 8'hFF, 1'b0, 2);
    check("R2 ref untouched", ref_bits, '0);
    bus_read(3'd5, 1'b0, got);
    check("R2 oe low", got[8], 1'b0);

    // R3 one update per long low pulse
    bus_write(3'd0, 8'h3C, 1'b1, 10);
    check("R3 single shift", ref_bits, 128'h3C);

    // table walk
    syn_flag = 1'b1; inv_flag = 1'b0; line_clk_lvl = 1'b1; score = 8'hA5;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        bus_read(VEC[i][19:17], 1'b1, got);
        if (got[8]) check("R8/R9 read", got, VEC[i][8:0]);
        else        check("R9 oe", got[8], VEC[i][8]);
      end else begin
        bus_write(VEC[i][19:17], VEC[i][16:9], 1'b1, 2);
      end
    end
    check("R6 thr_norm", thr_norm, 8'h9A);
    check("R6 thr_inv", thr_inv, 8'h34);

    // R4 reference: 16 writes
    for (int i = 0; i < 16; i++) wb[i] = 8'(8'h1D * (i + 1) ^ 8'h80);
    for (int i = 0; i < 16; i++) bus_write(3'd0, wb[i], 1'b1, 1);
    for (int p = 0; p < 128; p++) exp_v[p] = wb[15 - p / 8][p % 8];
    check("R4 ref full", ref_bits, exp_v);

    // R5 mask: 17 writes, oldest pushed out
    for (int i = 0; i < 17; i++) wb[i] = 8'(8'h37 * i + 8'h05);
    for (int i = 0; i < 17; i++) bus_write(3'd1, wb[i], 1'b1, 1);
    for (int p = 0; p < 128; p++) exp_v[p] = wb[16 - p / 8][p % 8];
    check("R5 mask overflow", mask_bits, exp_v);

    // R10 line shifting with load clear
    exp_v = '0;
    for (int i = 0; i < 11; i++) begin
      line_bit(1'((i * 5 + 1) % 3 == 0));
      exp_v = {exp_v[126:0], 1'((i * 5 + 1) % 3 == 0)};
    end
    check("R10 line shift", sr_bits, exp_v);
    bus_read(3'd4, 1'b1, got);
    check("R9 sr read", got, {1'b1, exp_v[7:0]});

    // R11 bus write ignored while load clear
    bus_write(3'd4, 8'hEE, 1'b1, 1);
    check("R11 ignored", sr_bits, exp_v);

    // R7 control positions, then load mode
    bus_write(3'd3, 8'h1B, 1'b1, 1);
    check("R7 ctrl", {prbs_mode, master_mode, sout_en_n, clear_n, sr_load}, 5'b11011);
    line_bit(1'b1);
    line_bit(1'b0);
    check("R10 tick ignored", sr_bits, exp_v);
    for (int i = 0; i < 16; i++) wb[i] = 8'(8'h81 + 8'h0B * i);
    for (int i = 0; i < 16; i++) bus_write(3'd4, wb[i], 1'b1, 1);
    for (int p = 0; p < 128; p++) exp_v[p] = wb[15 - p / 8][p % 8];
    check("R11 bus load", sr_bits, exp_v);
    bus_read(3'd4, 1'b1, got);
    check("R9 sr low byte", got, {1'b1, wb[15]});

    // R12 serial output gating
    bus_write(3'd3, 8'h08, 1'b1, 1);
    check("R12 ser_out enabled", ser_out, wb[0][7]);
    bus_write(3'd3, 8'h0C, 1'b1, 1);
    check("R12 ser_out disabled", ser_out, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule